// File: doc/BRIEF.md
# Two-Bank Programmable Switch Matrix

The block is a configurable crossbar between two equal banks of I/O cells, bank A and bank B. Each cell carries a 2-bit mode code, a source-select index and a constant-level bit. An output cell takes its value from the cell named by its index in the opposite bank. Depending on the mode it passes that value straight through, passes its complement, or ignores it and drives a fixed level. A cell in input mode releases its pin and offers the pin value to the matrix. Any number of cells in the other bank may read that value at once.

The path from pin inputs to pin outputs has no state. A configuration change or a pin change shows up on the outputs in the same cycle. Bank size is a parameter, and the index width follows from it.

Top module: `sw_matrix`

## Requirements
- R1: Routing only crosses banks. The select index of a bank A cell names a bank B cell, and the select index of a bank B cell names a bank A cell. Index k names cell k of the opposite bank.
- R2: Mode code 2'b00 puts a cell in input mode. The cell drives oe_o=0 and out_o=0.
- R3: Mode code 2'b01 is the non-inverting output. The cell drives oe_o=1, and out_o equals the pin input of the selected opposite-bank cell.
- R4: Mode code 2'b10 is the inverting output. The cell drives oe_o=1, and out_o is the complement of the pin input of the selected opposite-bank cell.
- R5: Mode code 2'b11 is the fixed output. The cell drives oe_o=1, and out_o equals the cell's level bit. Pin inputs have no effect on it.
- R6: One input-mode cell can feed every cell of the opposite bank at the same time.
- R7: A cell in mode 2'b01 or 2'b10 drives out_o=0 when its selected source cell is not in input mode.
- R8: A cell in mode 2'b01 or 2'b10 drives out_o=0 when its select index is N_CELLS or higher.
- R9: Outputs are a combinational function of the inputs. A pin change reaches out_o with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_pin_i | input | N_CELLS | Pin input values of bank A |
| a_mode_i | input | 2*N_CELLS | Mode codes of bank A, cell k in bits [2k+1:2k] |
| a_sel_i | input | SEL_W*N_CELLS | Bank B source index per bank A cell |
| a_lvl_i | input | N_CELLS | Fixed-output level per bank A cell |
| b_pin_i | input | N_CELLS | Pin input values of bank B |
| b_mode_i | input | 2*N_CELLS | Mode codes of bank B |
| b_sel_i | input | SEL_W*N_CELLS | Bank A source index per bank B cell |
| b_lvl_i | input | N_CELLS | Fixed-output level per bank B cell |
| a_out_o | output | N_CELLS | Output values of bank A |
| a_oe_o | output | N_CELLS | Output enables of bank A |
| b_out_o | output | N_CELLS | Output values of bank B |
| b_oe_o | output | N_CELLS | Output enables of bank B |

## Verification
Each bank in turn is set to each of the four mode codes on every cell. A rotating select pattern and two complementary pin patterns are applied, so a wrong source index, a lost inversion or a stuck output all show up. A single-source test drives every cell from one input pin and toggles that pin, which separates true fan-out from per-cell wiring. Sources left in output modes and indexes past the last cell check the forced-zero cases. The fixed-level and combinational tests change pins without a clock edge and show that constants ignore the pins while routed outputs follow them at once.

// File: rtl/sw_matrix_pkg.sv
package sw_matrix_pkg;
  typedef enum logic [1:0] {
    CELL_IN    = 2'b00,
    CELL_FOLLOW = 2'b01,
    CELL_INVERT = 2'b10,
    CELL_FIXED = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/sw_matrix_route.sv
module sw_matrix_route #(
  parameter int N_CELLS = 11,
  parameter int SEL_W   = $clog2(N_CELLS)
) (
  input  logic [N_CELLS-1:0]       src_pin_i,
  input  logic [2*N_CELLS-1:0]     src_mode_i,
  input  logic [SEL_W*N_CELLS-1:0] sel_i,
  output logic [N_CELLS-1:0]       val_o,
  output logic [N_CELLS-1:0]       vld_o
);
  import sw_matrix_pkg::*;

  for (genvar d = 0; d < N_CELLS; d++) begin : g_dst
    logic [SEL_W-1:0] sel;
    assign sel = sel_i[d*SEL_W +: SEL_W];
    always_comb begin
      vld_o[d] = 1'b0;
      val_o[d] = 1'b0;
      // an index past the last cell matches nothing
      for (int s = 0; s < N_CELLS; s++) begin
        if (sel == SEL_W'(s) && cell_mode_e'(src_mode_i[2*s +: 2]) == CELL_IN) begin
          vld_o[d] = 1'b1;
          val_o[d] = src_pin_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/sw_matrix_cell.sv
module sw_matrix_cell (
  input  logic [1:0] mode_i,
  input  logic       lvl_i,
  input  logic       vld_i,
  input  logic       val_i,
  output logic       out_o,
  output logic       oe_o
);
  import sw_matrix_pkg::*;

  always_comb begin
    oe_o  = 1'b1;
    out_o = 1'b0;
    unique case (cell_mode_e'(mode_i))
      CELL_IN:     oe_o  = 1'b0;
      CELL_FOLLOW: out_o = vld_i & val_i;
      CELL_INVERT: out_o = vld_i & ~val_i;
      CELL_FIXED:  out_o = lvl_i;
      default:     out_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sw_matrix.sv
module sw_matrix #(
  parameter int N_CELLS = 11,
  parameter int SEL_W   = $clog2(N_CELLS)
) (
  input  logic [N_CELLS-1:0]       a_pin_i,
  input  logic [2*N_CELLS-1:0]     a_mode_i,
  input  logic [SEL_W*N_CELLS-1:0] a_sel_i,
  input  logic [N_CELLS-1:0]       a_lvl_i,
  input  logic [N_CELLS-1:0]       b_pin_i,
  input  logic [2*N_CELLS-1:0]     b_mode_i,
  input  logic [SEL_W*N_CELLS-1:0] b_sel_i,
  input  logic [N_CELLS-1:0]       b_lvl_i,
  output logic [N_CELLS-1:0]       a_out_o,
  output logic [N_CELLS-1:0]       a_oe_o,
  output logic [N_CELLS-1:0]       b_out_o,
  output logic [N_CELLS-1:0]       b_oe_o
);
  logic [N_CELLS-1:0] a_val, a_vld, b_val, b_vld;

  // bank A reads bank B
  sw_matrix_route #(.N_CELLS(N_CELLS), .SEL_W(SEL_W)) i_route_a (
    .src_pin_i(b_pin_i), .src_mode_i(b_mode_i), .sel_i(a_sel_i),
    .val_o(a_val), .vld_o(a_vld)
  );
  // bank B reads bank A
  sw_matrix_route #(.N_CELLS(N_CELLS), .SEL_W(SEL_W)) i_route_b (
    .src_pin_i(a_pin_i), .src_mode_i(a_mode_i), .sel_i(b_sel_i),
    .val_o(b_val), .vld_o(b_vld)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    sw_matrix_cell i_cell_a (
      .mode_i(a_mode_i[2*k +: 2]), .lvl_i(a_lvl_i[k]),
      .vld_i(a_vld[k]), .val_i(a_val[k]),
      .out_o(a_out_o[k]), .oe_o(a_oe_o[k])
    );
    sw_matrix_cell i_cell_b (
      .mode_i(b_mode_i[2*k +: 2]), .lvl_i(b_lvl_i[k]),
      .vld_i(b_vld[k]), .val_i(b_val[k]),
      .out_o(b_out_o[k]), .oe_o(b_oe_o[k])
    );
  end
endmodule

// File: rtl/sw_matrix_chk.sv
module sw_matrix_chk #(
  parameter int N_CELLS = 11,
  parameter int SEL_W   = $clog2(N_CELLS)
) (
  input logic [N_CELLS-1:0]       a_pin_i,
  input logic [2*N_CELLS-1:0]     a_mode_i,
  input logic [SEL_W*N_CELLS-1:0] a_sel_i,
  input logic [N_CELLS-1:0]       a_lvl_i,
  input logic [N_CELLS-1:0]       b_pin_i,
  input logic [2*N_CELLS-1:0]     b_mode_i,
  input logic [SEL_W*N_CELLS-1:0] b_sel_i,
  input logic [N_CELLS-1:0]       b_lvl_i,
  input logic [N_CELLS-1:0]       a_out_o,
  input logic [N_CELLS-1:0]       a_oe_o,
  input logic [N_CELLS-1:0]       b_out_o,
  input logic [N_CELLS-1:0]       b_oe_o
);
  always_comb begin
    for (int k = 0; k < N_CELLS; k++) begin
      // R2
      p_input_released_r2: assert (a_mode_i[2*k +: 2] != 2'b00 || (!a_oe_o[k] && !a_out_o[k]));
      p_input_released_b_r2: assert (b_mode_i[2*k +: 2] != 2'b00 || (!b_oe_o[k] && !b_out_o[k]));
      // R5
      p_fixed_level_r5: assert (a_mode_i[2*k +: 2] != 2'b11 || (a_oe_o[k] && a_out_o[k] == a_lvl_i[k]));
      p_fixed_level_b_r5: assert (b_mode_i[2*k +: 2] != 2'b11 || (b_oe_o[k] && b_out_o[k] == b_lvl_i[k]));
      // R3 R4: any routed output mode enables the pin
      p_routed_enabled_r3: assert (a_mode_i[2*k +: 2] == 2'b00 || a_oe_o[k]);
      p_routed_enabled_b_r4: assert (b_mode_i[2*k +: 2] == 2'b00 || b_oe_o[k]);
      // R8
      p_sel_range_r8: assert (!(a_mode_i[2*k +: 2] inside {2'b01, 2'b10}) ||
                              int'(a_sel_i[k*SEL_W +: SEL_W]) < N_CELLS || !a_out_o[k]);
      p_sel_range_b_r8: assert (!(b_mode_i[2*k +: 2] inside {2'b01, 2'b10}) ||
                                int'(b_sel_i[k*SEL_W +: SEL_W]) < N_CELLS || !b_out_o[k]);
    end
  end
endmodule

bind sw_matrix sw_matrix_chk #(.N_CELLS(N_CELLS), .SEL_W(SEL_W)) i_sw_matrix_chk (.*);

// File: tb/test_sw_matrix.sv
module test_sw_matrix;
  localparam int N  = 11;
  localparam int SW = $clog2(N);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    a_pin = '0, b_pin = '0, a_lvl = '0, b_lvl = '0;
  logic [2*N-1:0]  a_mode = '0, b_mode = '0;
  logic [SW*N-1:0] a_sel = '0, b_sel = '0;
  logic [N-1:0]    a_out, a_oe, b_out, b_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  sw_matrix #(.N_CELLS(N), .SEL_W(SW)) i_sw_matrix (
    .a_pin_i(a_pin), .a_mode_i(a_mode), .a_sel_i(a_sel), .a_lvl_i(a_lvl),
    .b_pin_i(b_pin), .b_mode_i(b_mode), .b_sel_i(b_sel), .b_lvl_i(b_lvl),
    .a_out_o(a_out), .a_oe_o(a_oe), .b_out_o(b_out), .b_oe_o(b_oe)
  );

  // expected {oe,out} of one cell from the requirement text
  function automatic logic [1:0] model(input logic [1:0] m, input int s, input logic lvl,
                                       input logic [N-1:0] opin, input logic [2*N-1:0] omode);
    logic ok, d;
    ok = 1'b0;
    d  = 1'b0;
    if (s < N) begin
      ok = (omode[2*s +: 2] == 2'b00);
      d  = opin[s];
    end
    case (m)
      2'b00:   return 2'b00;
      2'b01:   return {1'b1, ok & d};
      2'b10:   return {1'b1, ok & ~d};
      default: return {1'b1, lvl};
    endcase
  endfunction

  task automatic check_all(input string tag);
    for (int k = 0; k < N; k++) begin
      logic [1:0] ea, eb;
      ea = model(a_mode[2*k +: 2], int'(a_sel[k*SW +: SW]), a_lvl[k], b_pin, b_mode);
      eb = model(b_mode[2*k +: 2], int'(b_sel[k*SW +: SW]), b_lvl[k], a_pin, a_mode);
      n_checks += 2;
      if ({a_oe[k], a_out[k]} !== ea) begin
        n_fail++;
        $display("FAIL %s cell A%0d oe/out=%b%b expected %b", tag, k, a_oe[k], a_out[k], ea);
      end
      if ({b_oe[k], b_out[k]} !== eb) begin
        n_fail++;
        $display("FAIL %s cell B%0d oe/out=%b%b expected %b", tag, k, b_oe[k], b_out[k], eb);
      end
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();  // R2: all cells in input mode
    a_mode = '0; b_mode = '0;
    settle();
    n_checks++;
    if (a_oe !== '0 || b_oe !== '0 || a_out !== '0 || b_out !== '0) begin
      n_fail++;
      $display("FAIL R2 idle oe=%h/%h out=%h/%h expected all 0", a_oe, b_oe, a_out, b_out);
    end
    check_all("R2");
  endtask

  // R1 R3 R4 R5: every mode on every cell, rotating selects, two pin patterns
  task automatic t_modes();
    for (int bank = 0; bank < 2; bank++) begin
      for (int m = 0; m < 4; m++) begin
        for (int rot = 1; rot < 4; rot++) begin
          for (int k = 0; k < N; k++) begin
            if (bank == 0) begin
              a_mode[2*k +: 2] = 2'(m); b_mode[2*k +: 2] = 2'b00;
              a_sel[k*SW +: SW] = SW'((k + rot) % N);
            end else begin
              b_mode[2*k +: 2] = 2'(m); a_mode[2*k +: 2] = 2'b00;
              b_sel[k*SW +: SW] = SW'((k * rot + 2) % N);
            end
          end
          a_lvl = N'(11'h2B5) ^ N'(rot); b_lvl = ~a_lvl;
          a_pin = N'(11'h5A3); b_pin = N'(11'h1C6);
          settle(); check_all("R1/R3/R4/R5");
          a_pin = ~a_pin; b_pin = ~b_pin;
          settle(); check_all("R1/R3/R4/R5 inverted pins");
        end
      end
    end
  endtask

  task automatic t_fixed_ignores_pins();  // R5
    a_mode = '1; b_mode = '0; a_lvl = N'(11'h4D2);
    for (int p = 0; p < 4; p++) begin
      b_pin = N'(p * 11'h1F3); a_pin = ~b_pin;
      #1;
      n_checks++;
      if (a_out !== a_lvl || a_oe !== '1) begin
        n_fail++;
        $display("FAIL R5 fixed out=%h oe=%h expected %h oe=all", a_out, a_oe, a_lvl);
      end
    end
  endtask

  task automatic t_fanout();  // R6
    b_mode = '0; a_mode = {N{2'b01}};
    for (int k = 0; k < N; k++) a_sel[k*SW +: SW] = SW'(3);
    for (int v = 0; v < 2; v++) begin
      b_pin = '0; b_pin[3] = v[0];
      settle();
      n_checks++;
      if (a_out !== {N{v[0]}}) begin
        n_fail++;
        $display("FAIL R6 fanout out=%h expected %h", a_out, {N{v[0]}});
      end
      check_all("R6");
    end
  endtask

  task automatic t_bad_source();  // R7
    for (int k = 0; k < N; k++) begin
      b_mode[2*k +: 2] = 2'(1 + k % 3);
      a_mode[2*k +: 2] = (k % 2 == 0) ? 2'b01 : 2'b10;
      a_sel[k*SW +: SW] = SW'(k);
    end
    b_pin = '1; b_lvl = '1;
    settle();
    n_checks++;
    if (a_out !== '0) begin
      n_fail++;
      $display("FAIL R7 non-input source out=%h expected 0", a_out);
    end
    check_all("R7");
  endtask

  task automatic t_sel_range();  // R8
    b_mode = '0; b_pin = '1;
    for (int k = 0; k < N; k++) begin
      a_mode[2*k +: 2] = (k % 2 == 0) ? 2'b01 : 2'b10;
      a_sel[k*SW +: SW] = SW'(N + k % ((1 << SW) - N));
    end
    for (int v = 0; v < 2; v++) begin
      b_pin = {N{v[0]}};
      settle();
      n_checks++;
      if (a_out !== '0) begin
        n_fail++;
        $display("FAIL R8 out-of-range select out=%h expected 0", a_out);
      end
    end
  endtask

  task automatic t_comb();  // R9
    b_mode = {N{2'b01}}; a_mode = '0;
    for (int k = 0; k < N; k++) b_sel[k*SW +: SW] = SW'(N - 1 - k);
    a_pin = N'(11'h0F0);
    settle();
    @(posedge clk);
    #1 a_pin = ~a_pin;
    #1;
    n_checks++;
    if (b_out !== {<<{a_pin}}) begin
      n_fail++;
      $display("FAIL R9 no-edge update out=%h expected %h", b_out, {<<{a_pin}});
    end
    check_all("R9");
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_modes();
    t_fixed_ignores_pins();
    t_fanout();
    t_bad_source();
    t_sel_range();
    t_comb();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule